// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Receiver

This block is a write-only I2C target that holds the programming registers of a tuner frequency synthesizer. It samples the SCL and SDA lines with a fast system clock, finds START and STOP conditions, and compares the first byte of each transfer with its chip address. Five bits of that address are fixed. The two low bits come from a two-bit address-select input. The direction bit must show a write. Every byte it accepts is acknowledged by pulling SDA low for the ninth clock.

After the address, the data bytes are handled in pairs. The top bit of the first byte of a pair selects its destination. A clear top bit makes the pair a 15-bit divider word. A set top bit makes the pair a control byte plus a band-switch byte. A transfer may therefore carry a divider pair, a control pair, or both pairs in either order.

Both bytes of a pair are staged, and the pair is committed only once its second byte has been acknowledged. A one-cycle update pulse marks the commit. A transfer that is cut short therefore never produces a half-written register. A START that arrives in the middle of a byte abandons the current transfer and begins address matching again.

Top module: `synth_ctl_rx`

## Requirements
- R1: After reset the outputs are as follows. `band_on` is 0, `amp_off` is 1, `ref_sel` is 2'b01 (the 1/1024 reference ratio), `cp_hi` is 0, `test_bits` is 0, `div_word` is 0, and `sda_drive_low`, `div_upd` and `ctl_upd` are 0.
- R2: An address byte of 1,1,0,0,0,`addr_sel[1]`,`addr_sel[0]` sent MSB first, followed by a direction bit of 0, is acknowledged. `sda_drive_low` is 1 while SCL is high in the ninth clock.
- R3: Two kinds of address byte are refused: one whose upper seven bits do not match, and one whose direction bit is 1. The block gives no acknowledge for that byte or for any later byte, and changes no register until the next START.
- R4: The block acknowledges up to four data bytes after an accepted address. It does not acknowledge a fifth data byte, and that byte changes nothing.
- R5: A pair whose first byte has bit 7 = 0 sets `div_word` to {first[6:0], second[7:0]}. `div_upd` pulses for one cycle.
- R6: A pair whose first byte has bit 7 = 1 loads the following fields:
  - `cp_hi` from first[6], `test_bits` from first[5:3], `ref_sel` from first[2:1] and `amp_off` from first[0].
  - `band_on` from second[3:0].
  - `ctl_upd` pulses for one cycle.
- R7: One transfer may carry a divider pair and a control pair in either order. Both pairs are applied, in the order they are received, and each gets its own pulse.
- R8: A pair that is not completed leaves every register unchanged and gives no pulse. This covers a pair ended by a STOP after its first byte, and a pair interrupted by a START.
- R9: A START detected while a byte is being shifted abandons the transfer. The byte that follows is treated as a new address byte.
- R10: `sda_drive_low` changes only while SCL is low, except that a START or STOP releases it. It is released after the falling SCL edge that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 2 | Low two bits of the chip address |
| sda_drive_low | output | 1 | 1 = pull SDA low (acknowledge) |
| div_word | output | 15 | Committed divider word |
| cp_hi | output | 1 | Charge-pump current select (0 = low current) |
| test_bits | output | 3 | Committed test-mode field |
| ref_sel | output | 2 | Reference ratio select {RSa, RSb} |
| amp_off | output | 1 | 1 = tuning amplifier off |
| band_on | output | 4 | Band-switch enables, 1 = on |
| div_upd | output | 1 | One-cycle pulse when a divider pair commits |
| ctl_upd | output | 1 | One-cycle pulse when a control pair commits |

## Verification
The bench builds the block with its defaults: two synchroniser stages and a limit of four data bytes. A four-byte limit lets a fifth byte be sent after both pair orders, so its refusal can be observed at the ports. A two-stage synchroniser keeps the edge-detection delay to about three cycles. That fits inside an eight-cycle quarter bit, so acknowledge timing and a START placed mid-byte can be exercised at a fast simulated bus rate. Every commit pulse is matched against a queue of expected pairs.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

    localparam int          BYTE_BITS   = 8;
    localparam logic [4:0]  ADDR_PREFIX = 5'b11000;
    localparam int          DIV_W       = 15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic       cp_hi;
        logic [2:0] test;
        logic [1:0] ref_sel;
        logic       amp_off;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{cp_hi: 1'b0, test: 3'b000, ref_sel: 2'b01, amp_off: 1'b1};

    function automatic logic addr_ok(input logic [7:0] b, input logic [1:0] sel);
        return (b[7:3] == ADDR_PREFIX) && (b[2:1] == sel) && (b[0] == 1'b0);
    endfunction

    function automatic ctl_t ctl_from_byte(input logic [6:0] b);
        ctl_t c;
        c.cp_hi   = b[6];
        c.test    = b[5:3];
        c.ref_sel = b[2:1];
        c.amp_off = b[0];
        return c;
    endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_prev;
    logic              sda_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh[g] <= 1'b1;
                    sda_sh[g] <= 1'b1;
                end else begin
                    scl_sh[g] <= scl_in;
                    sda_sh[g] <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh[g] <= 1'b1;
                    sda_sh[g] <= 1'b1;
                end else begin
                    scl_sh[g] <= scl_sh[g-1];
                    sda_sh[g] <= sda_sh[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_sh[STAGES-1];
            sda_prev <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
    import synth_ctl_pkg::*;
#(
    parameter int MAX_DATA = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] addr_sel,
    output logic       sda_low,
    output logic       byte_vld,
    output logic [7:0] byte_data
);
    localparam int                BCW       = $clog2(BYTE_BITS + 1);
    localparam logic [BCW-1:0]    BITS_FULL = BCW'(BYTE_BITS);
    localparam int                DCW       = $clog2(MAX_DATA + 1);
    localparam logic [DCW-1:0]    DATA_MAX  = DCW'(MAX_DATA);

    rx_state_e          state;
    logic [7:0]         shreg;
    logic [BCW-1:0]     bitcnt;
    logic               in_addr;
    logic [DCW-1:0]     dcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            in_addr   <= 1'b0;
            dcnt      <= '0;
            sda_low   <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (start_det) begin
                state   <= ST_SHIFT;
                bitcnt  <= '0;
                in_addr <= 1'b1;
                dcnt    <= '0;
                sda_low <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_SHIFT: begin
                        if (scl_rise && bitcnt < BITS_FULL) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BITS_FULL) begin
                            if (in_addr) begin
                                in_addr <= 1'b0;
                                if (addr_ok(shreg, addr_sel)) begin
                                    state   <= ST_ACK;
                                    sda_low <= 1'b1;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (dcnt < DATA_MAX) begin
                                state     <= ST_ACK;
                                sda_low   <= 1'b1;
                                byte_vld  <= 1'b1;
                                byte_data <= shreg;
                                dcnt      <= dcnt + 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            bitcnt  <= '0;
                            state   <= ST_SHIFT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ACK_SET_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !scl_lvl); // R10
    AST_ACK_REL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        ($fell(sda_low) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl); // R10
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_low); // R9
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!sda_low && !byte_vld)); // R3
    AST_DATA_LIMIT: assert property (@(posedge clk) disable iff (rst)
        dcnt <= DATA_MAX); // R4

endmodule

// File: rtl/pair_decoder.sv
module pair_decoder
    import synth_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    output logic [DIV_W-1:0] div_word,
    output ctl_t             ctl,
    output logic [3:0]       band,
    output logic             div_upd,
    output logic             ctl_upd
);
    logic       second;
    logic [7:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            second   <= 1'b0;
            hold     <= '0;
            div_word <= '0;
            ctl      <= CTL_RESET;
            band     <= '0;
            div_upd  <= 1'b0;
            ctl_upd  <= 1'b0;
        end else begin
            div_upd <= 1'b0;
            ctl_upd <= 1'b0;
            if (frame_start) begin
                second <= 1'b0;
            end else if (byte_vld) begin
                if (!second) begin
                    hold   <= byte_data;
                    second <= 1'b1;
                end else begin
                    second <= 1'b0;
                    if (hold[7]) begin
                        ctl     <= ctl_from_byte(hold[6:0]);
                        band    <= byte_data[3:0];
                        ctl_upd <= 1'b1;
                    end else begin
                        div_word <= {hold[6:0], byte_data};
                        div_upd  <= 1'b1;
                    end
                end
            end
        end
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !div_upd |-> $stable(div_word)); // R8
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_upd |-> $stable({ctl, band})); // R8
    AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({div_upd, ctl_upd})); // R7
    AST_UPD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (div_upd || ctl_upd) |-> $past(byte_vld)); // R5

endmodule

// File: rtl/synth_ctl_rx.sv
module synth_ctl_rx
    import synth_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DATA    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [1:0]       addr_sel,
    output logic             sda_drive_low,
    output logic [DIV_W-1:0] div_word,
    output logic             cp_hi,
    output logic [2:0]       test_bits,
    output logic [1:0]       ref_sel,
    output logic             amp_off,
    output logic [3:0]       band_on,
    output logic             div_upd,
    output logic             ctl_upd
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic       byte_vld;
    logic [7:0] byte_data;
    ctl_t       ctl;

    bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rx_bit_engine #(.MAX_DATA(MAX_DATA)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .sda_low   (sda_drive_low),
        .byte_vld  (byte_vld),
        .byte_data (byte_data)
    );

    pair_decoder u_decode (
        .clk         (clk),
        .rst         (rst),
        .frame_start (start_det),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .div_word    (div_word),
        .ctl         (ctl),
        .band        (band_on),
        .div_upd     (div_upd),
        .ctl_upd     (ctl_upd)
    );

    assign cp_hi     = ctl.cp_hi;
    assign test_bits = ctl.test;
    assign ref_sel   = ctl.ref_sel;
    assign amp_off   = ctl.amp_off;

endmodule

// File: tb/synth_ctl_rx_bench.sv
module synth_ctl_rx_bench;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b10;
    logic        sda_drive_low;
    logic [14:0] div_word;
    logic        cp_hi, amp_off, div_upd, ctl_upd;
    logic [2:0]  test_bits;
    logic [1:0]  ref_sel;
    logic [3:0]  band_on;
    logic        sda_bus;

    assign sda_bus = sda_m & ~sda_drive_low;

    always #2 clk = ~clk;

    synth_ctl_rx u_synth_ctl_rx (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .addr_sel(addr_sel),
        .sda_drive_low(sda_drive_low), .div_word(div_word), .cp_hi(cp_hi),
        .test_bits(test_bits), .ref_sel(ref_sel), .amp_off(amp_off),
        .band_on(band_on), .div_upd(div_upd), .ctl_upd(ctl_upd)
    );

    typedef struct packed {
        logic        is_ctl;
        logic [14:0] val;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] mk_div(input logic [7:0] a, input logic [7:0] b);
        return {a[6:0], b};
    endfunction

    function automatic logic [14:0] mk_ctl(input logic [7:0] a, input logic [7:0] b);
        return {a[6:0], b[3:0]} & 15'h07FF;
    endfunction

    function automatic logic [14:0] ports_ctl();
        return {4'b0, cp_hi, test_bits, ref_sel, amp_off, band_on};
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wq(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        wq(Q); sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        acked = sda_drive_low;
        wq(Q); scl_m = 1'b0;
    endtask

    task automatic push_exp(input logic is_ctl, input logic [14:0] v);
        exp_t e;
        e.is_ctl = is_ctl;
        e.val    = v;
        q.push_back(e);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (div_upd || ctl_upd)) begin
            if (q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R8: unexpected update actual div=%0h ctl=%0h expected none",
                         div_word, ports_ctl());
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.is_ctl) begin
                    chk("R6 ctl_upd kind", {31'd0, ctl_upd}, 32'd1);
                    chk("R6 control fields", {17'd0, ports_ctl()}, {17'd0, e.val});
                end else begin
                    chk("R5 div_upd kind", {31'd0, div_upd}, 32'd1);
                    chk("R5 divider word", {17'd0, div_word}, {17'd0, e.val});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [14:0] keep_div, keep_ctl;
        wq(5);
        rst = 1'b0;
        wq(2);
        // R1 reset state
        chk("R1 band_on", {28'd0, band_on}, 32'd0);
        chk("R1 amp_off", {31'd0, amp_off}, 32'd1);
        chk("R1 ref_sel", {30'd0, ref_sel}, 32'd1);
        chk("R1 cp_hi", {31'd0, cp_hi}, 32'd0);
        chk("R1 test_bits", {29'd0, test_bits}, 32'd0);
        chk("R1 div_word", {17'd0, div_word}, 32'd0);
        chk("R1 sda_drive_low", {31'd0, sda_drive_low}, 32'd0);
        chk("R1 update pulses", {30'd0, div_upd, ctl_upd}, 32'd0);

        // R2 address accepted, R5 divider pair, R10 release
        bus_start();
        send_byte(8'hC4, a); chk("R2 address ack", {31'd0, a}, 32'd1);
        wq(Q - 2); chk("R10 released after ack", {31'd0, sda_drive_low}, 32'd0);
        send_byte(8'h12, a); chk("R4 data ack", {31'd0, a}, 32'd1);
        push_exp(1'b0, mk_div(8'h12, 8'h34));
        send_byte(8'h34, a); chk("R4 data ack", {31'd0, a}, 32'd1);
        bus_stop();
        chk("R5 div_word after pair", {17'd0, div_word}, 32'h1234);

        // R6 control pair alone
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'hEA, a);
        push_exp(1'b1, mk_ctl(8'hEA, 8'hF5));
        send_byte(8'hF5, a);
        bus_stop();
        chk("R6 band_on", {28'd0, band_on}, 32'h5);
        chk("R6 ref_sel", {30'd0, ref_sel}, 32'h1);

        // R7 control then divider
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h87, a);
        push_exp(1'b1, mk_ctl(8'h87, 8'h08));
        send_byte(8'h08, a);
        send_byte(8'h7F, a);
        push_exp(1'b0, mk_div(8'h7F, 8'hFF));
        send_byte(8'hFF, a); chk("R7 fourth byte ack", {31'd0, a}, 32'd1);
        bus_stop();
        chk("R7 div after CB,BB,D1,D2", {17'd0, div_word}, 32'h7FFF);
        chk("R7 amp_off after CB,BB,D1,D2", {31'd0, amp_off}, 32'd1);

        // R7 divider then control, R4 fifth byte refused
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h04, a);
        push_exp(1'b0, mk_div(8'h04, 8'h00));
        send_byte(8'h00, a);
        send_byte(8'hC0, a);
        push_exp(1'b1, mk_ctl(8'hC0, 8'h03));
        send_byte(8'h03, a);
        send_byte(8'h00, a); chk("R4 fifth byte no ack", {31'd0, a}, 32'd0);
        bus_stop();
        chk("R7 div after D1,D2,CB,BB", {17'd0, div_word}, 32'h0400);
        chk("R7 band after D1,D2,CB,BB", {28'd0, band_on}, 32'h3);

        // R3 wrong address and read direction
        keep_div = div_word; keep_ctl = ports_ctl();
        bus_start();
        send_byte(8'hC6, a); chk("R3 wrong address no ack", {31'd0, a}, 32'd0);
        send_byte(8'h11, a); chk("R3 later byte no ack", {31'd0, a}, 32'd0);
        send_byte(8'h22, a);
        bus_stop();
        chk("R3 div unchanged", {17'd0, div_word}, {17'd0, keep_div});
        bus_start();
        send_byte(8'hC5, a); chk("R3 read bit no ack", {31'd0, a}, 32'd0);
        send_byte(8'h91, a);
        send_byte(8'h0F, a);
        bus_stop();
        chk("R3 ctl unchanged", {17'd0, ports_ctl()}, {17'd0, keep_ctl});

        // R8 truncated pairs
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h55, a);
        bus_stop();
        chk("R8 div after truncated pair", {17'd0, div_word}, {17'd0, keep_div});
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'hFF, a);
        bus_stop();
        chk("R8 ctl after truncated pair", {17'd0, ports_ctl()}, {17'd0, keep_ctl});

        // R9 START in the middle of a byte
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h01, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0;
        send_byte(8'hC4, a); chk("R9 address after restart", {31'd0, a}, 32'd1);
        send_byte(8'h22, a);
        push_exp(1'b0, mk_div(8'h22, 8'h11));
        send_byte(8'h11, a);
        bus_stop();
        chk("R9 div after restart", {17'd0, div_word}, 32'h2211);

        // R2 other address select
        addr_sel = 2'b00;
        wq(4);
        bus_start();
        send_byte(8'hC0, a); chk("R2 address sel 00 ack", {31'd0, a}, 32'd1);
        send_byte(8'h00, a);
        push_exp(1'b0, mk_div(8'h00, 8'h80));
        send_byte(8'h80, a);
        bus_stop();
        chk("R5 div sel 00", {17'd0, div_word}, 32'h0080);

        wq(20);
        chk("R5 scoreboard drained", q.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule